// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the seven status flags of an I2C controller and serves the status read words that software polls. The bus engine raises single-cycle event strobes: a byte moved into the shift register, a byte received or sent, a start generated, an address phase done, a 10-bit header sent, and start or stop conditions seen on the bus. The block sets the matching flag from each strobe. The bus interface raises single-cycle access strobes for status register 1, status register 2, control register 1 and the data register. The block clears each flag either on a single data-register access or on an ordered pair of accesses.

Each ordered pair starts with a read of status register 1. That read arms a one-bit latch for each sequence. The next qualifying access consumes the latch and clears the flag. Any other register access disarms it, so a stale status read cannot clear a flag later. When a setting event and a clearing access land in the same cycle, the flag ends up set. All flag updates show on the outputs one clock after the strobe.

Top module: `i2c_stat_flags`

## Requirements
- R1: In reset and after it, the flag vector is 7'b1000000 (only transmit-empty set) and status word 1 reads 0x0080.
- R2: Transmit-empty (flag bit 6) is set when the engine moves the data register into the shift register. A data-register write clears it, except when the transmission-first input is high or transfer-complete is set.
- R3: Receive-full (flag bit 5) is set when a received byte completes while it is 0. A data-register read clears it.
- R4: A received byte that comes with arbitration lost does not set receive-full.
- R5: Stop-detected (flag bit 4) is set by a stop event only in slave role with acknowledge enabled. It clears only when a status-1 read is followed directly by a control-1 write.
- R6: Header-sent (flag bit 3) is set by a 10-bit header event without NACK. It clears through the status-1-read then control-1-write pair, or whenever peripheral enable is low.
- R7: Transfer-complete (flag bit 2) is set by a received byte while receive-full is 1, or by a sent byte while transmit-empty is 1. It clears on any data-register read or write and on a start or stop condition event.
- R8: Address-done (flag bit 1) is set by an address event without NACK. It clears only when a status-2 read directly follows a status-1 read.
- R9: Start-done (flag bit 0) is set by a start event. It clears when a data-register write directly follows a status-1 read.
- R10: Any other register access between the status-1 read and the qualifying access disarms that sequence. Repeated status-1 reads keep it armed.
- R11: A set event and a clearing access in the same cycle leave the flag set.
- R12: Status word 1 maps flag bits 0 to 4 onto bits 0 to 4, receive-full onto bit 6 and transmit-empty onto bit 7. Bit 5 and all bits above 7 read 0. Status word 2 bit 0 is 1 in master role (slave input low), and its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Peripheral enable |
| ack_en_i | input | 1 | Acknowledge enabled |
| slave_i | input | 1 | 1 = slave role, 0 = master role |
| tx_first_i | input | 1 | Shift register idle, next written byte goes straight to it |
| ev_start_i | input | 1 | Start condition generated |
| ev_addr_i | input | 1 | Address sent (master) or matched (slave) |
| ev_hdr10_i | input | 1 | First 10-bit header byte sent |
| ev_nack_i | input | 1 | Qualifies address/header event as NACKed |
| ev_stop_i | input | 1 | Stop condition seen on bus |
| ev_startdet_i | input | 1 | Start condition seen on bus |
| ev_dt_xfer_i | input | 1 | Data register moved to shift register |
| ev_tx_byte_i | input | 1 | Byte finished sending |
| ev_rx_byte_i | input | 1 | Byte with ACK finished receiving |
| ev_arlost_i | input | 1 | Arbitration lost with this byte |
| sts1_rd_i | input | 1 | Status register 1 read |
| sts2_rd_i | input | 1 | Status register 2 read |
| ctrl1_wr_i | input | 1 | Control register 1 write |
| dt_rd_i | input | 1 | Data register read |
| dt_wr_i | input | 1 | Data register write |
| flags_o | output | 7 | Flag vector |
| sts1_o | output | STS_W | Status word 1 |
| sts2_o | output | STS_W | Status word 2 |

## Verification
The bench builds the block with the default status-word width of 16. This puts the upper byte of both status words in view, so the bench can check that it reads zero. It also makes the status-1 layout check cover more than the 8 flag positions. At this width, the reserved bit and the bits above bit 7 are checked against a pattern that has receive-full and start-done set, so a shifted or swapped mapping shows up as a wrong value.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int NUM_FLAGS = 7;
  localparam int F_START = 0;
  localparam int F_ADDR  = 1;
  localparam int F_TDC   = 2;
  localparam int F_HDR   = 3;
  localparam int F_STOP  = 4;
  localparam int F_RXF   = 5;
  localparam int F_TXE   = 6;

  localparam int NUM_SEQ = 3;
  localparam int S_CTRL1 = 0;
  localparam int S_STS2  = 1;
  localparam int S_DTWR  = 2;
endpackage

// File: rtl/i2c_seq_arm.sv
module i2c_seq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic any_acc_i,
  input  logic qual_i,
  output logic fire_o
);
  logic armed_q;

  // arm wins; any other access consumes or disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (arm_i)     armed_q <= 1'b1;
    else if (any_acc_i) armed_q <= 1'b0;
  end

  assign fire_o = armed_q & qual_i & ~arm_i;
endmodule

// File: rtl/i2c_flag_bit.sv
module i2c_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_flag_pkg::*;
#(
  parameter int STS_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 ack_en_i,
  input  logic                 slave_i,
  input  logic                 tx_first_i,
  input  logic                 ev_start_i,
  input  logic                 ev_addr_i,
  input  logic                 ev_hdr10_i,
  input  logic                 ev_nack_i,
  input  logic                 ev_stop_i,
  input  logic                 ev_startdet_i,
  input  logic                 ev_dt_xfer_i,
  input  logic                 ev_tx_byte_i,
  input  logic                 ev_rx_byte_i,
  input  logic                 ev_arlost_i,
  input  logic                 sts1_rd_i,
  input  logic                 sts2_rd_i,
  input  logic                 ctrl1_wr_i,
  input  logic                 dt_rd_i,
  input  logic                 dt_wr_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [STS_W-1:0]     sts1_o,
  output logic [STS_W-1:0]     sts2_o
);
  localparam int LOW_W = 8;

  logic                 any_acc;
  logic [NUM_SEQ-1:0]   seq_qual;
  logic [NUM_SEQ-1:0]   seq_fire;
  logic [NUM_FLAGS-1:0] f_set;
  logic [NUM_FLAGS-1:0] f_clr;

  assign any_acc = sts1_rd_i | sts2_rd_i | ctrl1_wr_i | dt_rd_i | dt_wr_i;

  always_comb begin
    seq_qual          = '0;
    seq_qual[S_CTRL1] = ctrl1_wr_i;
    seq_qual[S_STS2]  = sts2_rd_i;
    seq_qual[S_DTWR]  = dt_wr_i;
  end

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    i2c_seq_arm u_arm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (sts1_rd_i),
      .any_acc_i(any_acc),
      .qual_i   (seq_qual[s]),
      .fire_o   (seq_fire[s])
    );
  end

  always_comb begin
    f_set = '0;
    f_clr = '0;
    f_set[F_START] = ev_start_i;
    f_clr[F_START] = seq_fire[S_DTWR];

    f_set[F_ADDR]  = ev_addr_i & ~ev_nack_i;
    f_clr[F_ADDR]  = seq_fire[S_STS2];

    f_set[F_TDC]   = (ev_rx_byte_i & flags_o[F_RXF]) | (ev_tx_byte_i & flags_o[F_TXE]);
    f_clr[F_TDC]   = dt_rd_i | dt_wr_i | ev_startdet_i | ev_stop_i;

    f_set[F_HDR]   = ev_hdr10_i & ~ev_nack_i;
    f_clr[F_HDR]   = seq_fire[S_CTRL1] | ~en_i;

    f_set[F_STOP]  = ev_stop_i & slave_i & ack_en_i;
    f_clr[F_STOP]  = seq_fire[S_CTRL1];

    f_set[F_RXF]   = ev_rx_byte_i & ~flags_o[F_RXF] & ~ev_arlost_i;
    f_clr[F_RXF]   = dt_rd_i;

    // byte bypasses the buffer when shifter idle or previous byte done
    f_set[F_TXE]   = ev_dt_xfer_i;
    f_clr[F_TXE]   = dt_wr_i & ~tx_first_i & ~flags_o[F_TDC];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    i2c_flag_bit #(.RST_VAL(i == F_TXE)) u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (f_set[i]),
      .clr_i (f_clr[i]),
      .q_o   (flags_o[i])
    );
  end

  always_comb begin
    sts1_o = '0;
    sts1_o[LOW_W-1:0] = {flags_o[F_TXE], flags_o[F_RXF], 1'b0, flags_o[F_STOP],
                         flags_o[F_HDR], flags_o[F_TDC], flags_o[F_ADDR], flags_o[F_START]};
    sts2_o = '0;
    sts2_o[0] = ~slave_i;
  end
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk
  import i2c_flag_pkg::*;
#(
  parameter int STS_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 ack_en_i,
  input logic                 slave_i,
  input logic                 ev_hdr10_i,
  input logic                 ev_addr_i,
  input logic                 ev_stop_i,
  input logic                 ev_startdet_i,
  input logic                 ev_rx_byte_i,
  input logic                 ev_tx_byte_i,
  input logic                 ev_arlost_i,
  input logic                 sts2_rd_i,
  input logic                 dt_rd_i,
  input logic                 dt_wr_i,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic [STS_W-1:0]     sts1_o
);
  a_r3_rxf_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_rd_i && !ev_rx_byte_i) |=> !flags_o[F_RXF]);

  a_r4_arlost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[F_RXF] && ev_arlost_i) |=> !flags_o[F_RXF]);

  a_r5_stop_role: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[F_STOP] && !(ev_stop_i && slave_i && ack_en_i)) |=> !flags_o[F_STOP]);

  a_r6_hdr_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ev_hdr10_i) |=> !flags_o[F_HDR]);

  a_r7_tdc_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dt_rd_i || dt_wr_i || ev_startdet_i || ev_stop_i) && !ev_rx_byte_i && !ev_tx_byte_i)
    |=> !flags_o[F_TDC]);

  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[F_ADDR] && !sts2_rd_i) |=> flags_o[F_ADDR]);

  a_r11_rxf_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_rx_byte_i && !flags_o[F_RXF] && !ev_arlost_i) |=> flags_o[F_RXF]);

  a_r12_sts1_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts1_o[7] == flags_o[F_TXE]) && (sts1_o[6] == flags_o[F_RXF]) && !sts1_o[5]
    && (sts1_o[4:0] == flags_o[4:0]));
endmodule

bind i2c_stat_flags i2c_stat_flags_chk #(.STS_W(STS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .ack_en_i     (ack_en_i),
  .slave_i      (slave_i),
  .ev_hdr10_i   (ev_hdr10_i),
  .ev_addr_i    (ev_addr_i),
  .ev_stop_i    (ev_stop_i),
  .ev_startdet_i(ev_startdet_i),
  .ev_rx_byte_i (ev_rx_byte_i),
  .ev_tx_byte_i (ev_tx_byte_i),
  .ev_arlost_i  (ev_arlost_i),
  .sts2_rd_i    (sts2_rd_i),
  .dt_rd_i      (dt_rd_i),
  .dt_wr_i      (dt_wr_i),
  .flags_o      (flags_o),
  .sts1_o       (sts1_o)
);

// File: tb/sim_i2c_stat_flags.sv
`timescale 1ns/1ps
module sim_i2c_stat_flags;
  localparam int STS_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1, ack_en_i = 1'b0, slave_i = 1'b0, tx_first_i = 1'b0;
  logic ev_start_i = 0, ev_addr_i = 0, ev_hdr10_i = 0, ev_nack_i = 0, ev_stop_i = 0;
  logic ev_startdet_i = 0, ev_dt_xfer_i = 0, ev_tx_byte_i = 0, ev_rx_byte_i = 0, ev_arlost_i = 0;
  logic sts1_rd_i = 0, sts2_rd_i = 0, ctrl1_wr_i = 0, dt_rd_i = 0, dt_wr_i = 0;
  logic [6:0]       flags_o;
  logic [STS_W-1:0] sts1_o, sts2_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_stat_flags #(.STS_W(STS_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .ack_en_i(ack_en_i), .slave_i(slave_i),
    .tx_first_i(tx_first_i), .ev_start_i(ev_start_i), .ev_addr_i(ev_addr_i),
    .ev_hdr10_i(ev_hdr10_i), .ev_nack_i(ev_nack_i), .ev_stop_i(ev_stop_i),
    .ev_startdet_i(ev_startdet_i), .ev_dt_xfer_i(ev_dt_xfer_i), .ev_tx_byte_i(ev_tx_byte_i),
    .ev_rx_byte_i(ev_rx_byte_i), .ev_arlost_i(ev_arlost_i), .sts1_rd_i(sts1_rd_i),
    .sts2_rd_i(sts2_rd_i), .ctrl1_wr_i(ctrl1_wr_i), .dt_rd_i(dt_rd_i), .dt_wr_i(dt_wr_i),
    .flags_o(flags_o), .sts1_o(sts1_o), .sts2_o(sts2_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clock: strobes set before the call are captured, then dropped
  task automatic tick();
    @(posedge clk);
    #1;
    {ev_start_i, ev_addr_i, ev_hdr10_i, ev_nack_i, ev_stop_i, ev_startdet_i} = '0;
    {ev_dt_xfer_i, ev_tx_byte_i, ev_rx_byte_i, ev_arlost_i} = '0;
    {sts1_rd_i, sts2_rd_i, ctrl1_wr_i, dt_rd_i, dt_wr_i} = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags in reset", 16'(flags_o), 16'h0040);
    chk("R1 sts1 in reset", sts1_o, 16'h0080);
    @(negedge clk); rst_ni = 1'b1;
    tick();
    chk("R1 flags after reset", 16'(flags_o), 16'h0040);
    chk("R12 sts2 master", sts2_o, 16'h0001);
  endtask

  task automatic t_tx();
    tx_first_i = 1'b1; dt_wr_i = 1; tick();
    chk("R2 first byte keeps txe", 16'(flags_o[6]), 16'h1);
    tx_first_i = 1'b0; dt_wr_i = 1; tick();
    chk("R2 write clears txe", 16'(flags_o[6]), 16'h0);
    ev_tx_byte_i = 1; tick();
    chk("R7 tx byte with txe=0 no tdc", 16'(flags_o[2]), 16'h0);
    ev_dt_xfer_i = 1; tick();
    chk("R2 xfer sets txe", 16'(flags_o[6]), 16'h1);
    ev_tx_byte_i = 1; tick();
    chk("R7 tx byte with txe=1 sets tdc", 16'(flags_o[2]), 16'h1);
    dt_wr_i = 1; tick();
    chk("R2 write with tdc keeps txe", 16'(flags_o[6]), 16'h1);
    chk("R7 write clears tdc", 16'(flags_o[2]), 16'h0);
  endtask

  task automatic t_rx();
    ev_rx_byte_i = 1; tick();
    chk("R3 rx sets rxf", 16'(flags_o[5]), 16'h1);
    ev_rx_byte_i = 1; tick();
    chk("R7 rx with rxf=1 sets tdc", 16'(flags_o[2]), 16'h1);
    dt_rd_i = 1; tick();
    chk("R3 read clears rxf", 16'(flags_o[5]), 16'h0);
    chk("R7 read clears tdc", 16'(flags_o[2]), 16'h0);
    ev_rx_byte_i = 1; ev_arlost_i = 1; tick();
    chk("R4 arlost no rxf", 16'(flags_o[5]), 16'h0);
    ev_rx_byte_i = 1; tick();
    ev_rx_byte_i = 1; tick();
    ev_startdet_i = 1; tick();
    chk("R7 start detect clears tdc", 16'(flags_o[2]), 16'h0);
    dt_rd_i = 1; tick();
    chk("R3 rxf cleared again", 16'(flags_o[5]), 16'h0);
  endtask

  task automatic t_stop();
    slave_i = 1'b1; ack_en_i = 1'b0; ev_stop_i = 1; tick();
    chk("R5 no ack no stopf", 16'(flags_o[4]), 16'h0);
    ack_en_i = 1'b1; ev_stop_i = 1; tick();
    chk("R5 slave stop sets", 16'(flags_o[4]), 16'h1);
    ctrl1_wr_i = 1; tick();
    chk("R5 ctrl1 alone keeps", 16'(flags_o[4]), 16'h1);
    sts1_rd_i = 1; tick();
    ctrl1_wr_i = 1; tick();
    chk("R5 sequence clears", 16'(flags_o[4]), 16'h0);
    slave_i = 1'b0; ev_stop_i = 1; tick();
    chk("R5 master stop ignored", 16'(flags_o[4]), 16'h0);
  endtask

  task automatic t_hdr();
    ev_hdr10_i = 1; ev_nack_i = 1; tick();
    chk("R6 nack no hdr", 16'(flags_o[3]), 16'h0);
    ev_hdr10_i = 1; tick();
    chk("R6 hdr set", 16'(flags_o[3]), 16'h1);
    sts1_rd_i = 1; tick();
    dt_rd_i = 1; tick();
    ctrl1_wr_i = 1; tick();
    chk("R10 interrupted seq keeps hdr", 16'(flags_o[3]), 16'h1);
    sts1_rd_i = 1; tick();
    ctrl1_wr_i = 1; tick();
    chk("R6 sequence clears hdr", 16'(flags_o[3]), 16'h0);
    ev_hdr10_i = 1; tick();
    en_i = 1'b0; tick();
    chk("R6 disable clears hdr", 16'(flags_o[3]), 16'h0);
    en_i = 1'b1;
  endtask

  task automatic t_addr();
    ev_addr_i = 1; ev_nack_i = 1; tick();
    chk("R8 nack no addr", 16'(flags_o[1]), 16'h0);
    ev_addr_i = 1; tick();
    sts2_rd_i = 1; tick();
    chk("R8 sts2 alone keeps", 16'(flags_o[1]), 16'h1);
    sts1_rd_i = 1; tick();
    ctrl1_wr_i = 1; tick();
    sts2_rd_i = 1; tick();
    chk("R10 cancelled keeps addr", 16'(flags_o[1]), 16'h1);
    sts1_rd_i = 1; tick();
    sts1_rd_i = 1; tick();
    sts2_rd_i = 1; tick();
    chk("R8 R10 repeated arm clears", 16'(flags_o[1]), 16'h0);
  endtask

  task automatic t_start();
    ev_start_i = 1; tick();
    dt_wr_i = 1; tick();
    chk("R9 write alone keeps start", 16'(flags_o[0]), 16'h1);
    sts1_rd_i = 1; tick();
    dt_wr_i = 1; tick();
    chk("R9 sequence clears start", 16'(flags_o[0]), 16'h0);
    ev_dt_xfer_i = 1; tick();
  endtask

  task automatic t_set_wins();
    ev_rx_byte_i = 1; dt_rd_i = 1; tick();
    chk("R11 rxf set wins", 16'(flags_o[5]), 16'h1);
    sts1_rd_i = 1; tick();
    ev_start_i = 1; dt_wr_i = 1; tick();
    chk("R11 start set wins", 16'(flags_o[0]), 16'h1);
  endtask

  task automatic t_layout();
    slave_i = 1'b1; tick();
    chk("R12 flags pattern", 16'(flags_o), 16'h0021);
    chk("R12 sts1 layout", sts1_o, 16'h0041);
    chk("R12 sts2 slave", sts2_o, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_tx();
    t_rx();
    t_stop();
    t_hdr();
    t_addr();
    t_start();
    t_set_wins();
    t_layout();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule